// File: doc/BRIEF.md
# Event Link Frame Multiplexer

This block builds the two-byte word that an event link carries in every event-clock cycle, and it also holds the matching receive-side splitter. The low byte of every transmitted word is the event code. The high byte is shared between two users, and the owner changes on every cycle. On even cycles it carries an 8-bit sample of eight broadcast bus signals. On odd cycles it carries the segmented data channel. A segment is written into a 16-entry byte buffer and then launched with a send request. Each byte comes with a K-character flag, which a downstream 8b/10b encoder uses. Serialization and line coding are outside this block.

On the data cycles the transmitter runs through a small frame sequence. It sends a start K-character, then a length byte, then the payload bytes from the buffer, then an XOR checksum. On data cycles with nothing to send it emits a comma. The receiver starts in a hunt state and takes its cycle phase from the first comma it sees. After that it splits the incoming stream back into the event code, the bus byte and the payload bytes. At the end of each segment it raises an end pulse, and a bad flag when the segment is faulty.

Transmit states: `TX_IDLE` (commas on data cycles) → `TX_SOF` on an accepted send request → `TX_LEN` → `TX_PAY` → `TX_SUM` after the last payload byte → back to `TX_IDLE`. The transmitter moves between these states only on data cycles, except for the first step out of `TX_IDLE`, which happens on any cycle. Receive states: `RX_HUNT` → `RX_SOF` on the first comma. `RX_SOF` → `RX_LEN` on a start character. `RX_LEN` → `RX_PAY` on a valid length, or back to `RX_SOF` on an invalid one. `RX_PAY` → `RX_SUM` after the last byte, or back to `RX_SOF` on a K-character. `RX_SUM` → `RX_SOF`.

Top module: `evlink_frame_mux`

## Requirements
- R1: While reset is held low, `tx_word`, `tx_k`, `tx_busy`, `rx_aligned`, `rx_event`, `rx_bus`, `rx_dat_valid`, `rx_seg_end` and `rx_seg_bad` are all zero.
- R2: Each transmitted word holds in bits 7:0 the `ev_code` value sampled at the clock edge that produced it, and `tx_k[0]` is always 0.
- R3: The first word after reset is a bus cycle, and bus and data cycles then strictly alternate. On a bus cycle bits 15:8 carry `bus_in` as sampled at that edge, with `tx_k[1]`=0.
- R4: On a data cycle with no segment in progress, bits 15:8 carry the comma 0xBC with `tx_k[1]`=1.
- R5: After an accepted send request with `send_len`=n, the following data cycles carry, in order: the start character 0x5C with k=1, then the length byte n+1 with k=0, then buffer entries 0 to n, then the XOR of those payload bytes.
- R6: `tx_busy` is high from the edge that accepts a send request until the edge that emits the checksum. While it is high, a further `send_req` and any `buf_we` write are ignored.
- R7: After reset the receiver keeps `rx_aligned`=0 and produces no outputs until it sees 0xBC with `rx_k[1]`=1. It treats that word as a data cycle, alternates from then on, and stays aligned until the next reset.
- R8: Once aligned, `rx_event` shows the low byte of the previous input word, or 0 if `rx_k[0]` was set. `rx_bus` takes the high byte of each bus-cycle input and holds it between bus cycles.
- R9: Each payload byte of a received segment appears on `rx_dat_byte` with a one-cycle `rx_dat_valid`, one byte per data cycle, in order.
- R10: `rx_seg_end` pulses once per segment, one cycle after the checksum byte. `rx_seg_bad` is set with it when the checksum differs from the XOR of the payload. It also ends a segment as bad when the length byte is 0, above 16 or a K-character, and when a K-character arrives in place of a payload byte.
- R11: A segment of the full 16 bytes (`send_len`=15) and a segment of 1 byte (`send_len`=0) both go through intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_code | input | 8 | Event code for the low byte |
| bus_in | input | 8 | Broadcast bus bits sampled on bus cycles |
| buf_we | input | 1 | Segment buffer write enable |
| buf_waddr | input | 4 | Segment buffer write address |
| buf_wdata | input | 8 | Segment buffer write data |
| send_req | input | 1 | Launch a segment |
| send_len | input | 4 | Payload length minus one |
| tx_word | output | 16 | Outgoing two-byte word |
| tx_k | output | 2 | Per-byte K-character flags |
| tx_busy | output | 1 | Segment in progress |
| rx_word | input | 16 | Incoming two-byte word |
| rx_k | input | 2 | Incoming per-byte K flags |
| rx_aligned | output | 1 | Receiver has locked its phase |
| rx_event | output | 8 | Received event code |
| rx_bus | output | 8 | Last received bus byte |
| rx_dat_valid | output | 1 | Payload byte strobe |
| rx_dat_byte | output | 8 | Payload byte |
| rx_seg_end | output | 1 | Segment finished |
| rx_seg_bad | output | 1 | Finished segment was faulty |

## Verification
The transmitter is fed an event code and bus value that change on every cycle, driven by a shift register. This checks that the low byte and the bus cycles track their own inputs and never take values from the data lane. Segments of 3, 16 and 1 bytes are looped back to the receiver. The 3-byte send has a second request and a buffer overwrite placed inside it, so an ignored request shows up as a missing or altered frame at the receiver. A separate hand-built stream is then fed to the receiver directly. It carries bus bytes equal to 0xBC but not marked K before any real comma, which must not cause lock. It also carries a segment with a wrong checksum and a segment with an oversized length, which must end as bad with the right number of bytes.

// File: rtl/evlink_pkg.sv
package evlink_pkg;
    localparam logic [7:0] K_COMMA = 8'hBC;
    localparam logic [7:0] K_SOF   = 8'h5C;

    typedef enum logic [2:0] {
        TX_IDLE, TX_SOF, TX_LEN, TX_PAY, TX_SUM
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_HUNT, RX_SOF, RX_LEN, RX_PAY, RX_SUM
    } rx_state_e;
endpackage

// File: rtl/evlink_seg_buf.sv
module evlink_seg_buf #(
    parameter  int DEPTH = 16,
    parameter  int DW    = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (we && (waddr == AW'(i)))
                mem[i] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/evlink_tx.sv
module evlink_tx
    import evlink_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    ev_code,
    input  logic [7:0]    bus_in,
    input  logic          send_req,
    input  logic [AW-1:0] send_len,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic [15:0]   tx_word,
    output logic [1:0]    tx_k,
    output logic          busy
);
    tx_state_e     st, st_nx;
    logic          ph;          // 1: current cycle is a data cycle
    logic [CW-1:0] len_q;
    logic [AW-1:0] idx;
    logic [7:0]    acc;
    logic [7:0]    lane_b;
    logic          lane_k;
    logic          last_b;

    assign last_b = (CW'(idx) == (len_q - CW'(1)));

    always_comb begin
        st_nx = st;
        unique case (st)
            TX_IDLE: if (send_req)      st_nx = TX_SOF;
            TX_SOF:  if (ph)            st_nx = TX_LEN;
            TX_LEN:  if (ph)            st_nx = TX_PAY;
            TX_PAY:  if (ph && last_b)  st_nx = TX_SUM;
            TX_SUM:  if (ph)            st_nx = TX_IDLE;
            default:                    st_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TX_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        lane_b = bus_in;
        lane_k = 1'b0;
        if (ph) begin
            unique case (st)
                TX_IDLE: begin lane_b = K_COMMA;     lane_k = 1'b1; end
                TX_SOF:  begin lane_b = K_SOF;       lane_k = 1'b1; end
                TX_LEN:  lane_b = 8'(len_q);
                TX_PAY:  lane_b = rd_data;
                TX_SUM:  lane_b = acc;
                default: begin lane_b = K_COMMA;     lane_k = 1'b1; end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph      <= 1'b0;
            tx_word <= '0;
            tx_k    <= '0;
            len_q   <= '0;
            idx     <= '0;
            acc     <= '0;
        end else begin
            ph      <= ~ph;
            tx_word <= {lane_b, ev_code};
            tx_k    <= {lane_k, 1'b0};
            if (st == TX_IDLE && send_req)
                len_q <= CW'(send_len) + CW'(1);
            if (ph && st == TX_LEN) begin
                idx <= '0;
                acc <= '0;
            end else if (ph && st == TX_PAY) begin
                idx <= idx + AW'(1);
                acc <= acc ^ rd_data;
            end
        end
    end

    assign rd_addr = idx;
    assign busy    = (st != TX_IDLE);
endmodule

// File: rtl/evlink_rx.sv
module evlink_rx
    import evlink_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] rx_word,
    input  logic [1:0]  rx_k,
    output logic        aligned,
    output logic [7:0]  ev_out,
    output logic [7:0]  bus_out,
    output logic        dat_valid,
    output logic [7:0]  dat_byte,
    output logic        seg_end,
    output logic        seg_bad
);
    rx_state_e     st, st_nx;
    logic          dph;         // 1: incoming word is a data cycle
    logic [CW-1:0] len_q;
    logic [AW-1:0] cnt;
    logic [7:0]    acc;
    logic [7:0]    hb;
    logic          hk;
    logic          is_comma;
    logic          bad_len;
    logic          last_b;

    assign hb       = rx_word[15:8];
    assign hk       = rx_k[1];
    assign is_comma = hk && (hb == K_COMMA);
    assign bad_len  = hk || (hb == 8'd0) || (hb > 8'(DEPTH));
    assign last_b   = (CW'(cnt) == (len_q - CW'(1)));

    always_comb begin
        st_nx = st;
        unique case (st)
            RX_HUNT: if (is_comma) st_nx = RX_SOF;
            RX_SOF:  if (dph && hk && hb == K_SOF) st_nx = RX_LEN;
            RX_LEN:  if (dph) st_nx = bad_len ? RX_SOF : RX_PAY;
            RX_PAY:  if (dph && hk)          st_nx = RX_SOF;
                     else if (dph && last_b) st_nx = RX_SUM;
            RX_SUM:  if (dph) st_nx = RX_SOF;
            default: st_nx = RX_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RX_HUNT;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aligned   <= 1'b0;
            dph       <= 1'b0;
            ev_out    <= '0;
            bus_out   <= '0;
            dat_valid <= 1'b0;
            dat_byte  <= '0;
            seg_end   <= 1'b0;
            seg_bad   <= 1'b0;
            len_q     <= '0;
            cnt       <= '0;
            acc       <= '0;
        end else begin
            dat_valid <= 1'b0;
            seg_end   <= 1'b0;
            seg_bad   <= 1'b0;
            if (st == RX_HUNT) begin
                if (is_comma) begin
                    aligned <= 1'b1;
                    dph     <= 1'b0;
                end
            end else begin
                dph    <= ~dph;
                ev_out <= rx_k[0] ? 8'h00 : rx_word[7:0];
                if (!dph)
                    bus_out <= hb;
                if (dph) begin
                    unique case (st)
                        RX_LEN: begin
                            len_q <= hb[CW-1:0];
                            cnt   <= '0;
                            acc   <= '0;
                            if (bad_len) begin
                                seg_end <= 1'b1;
                                seg_bad <= 1'b1;
                            end
                        end
                        RX_PAY: begin
                            if (hk) begin
                                seg_end <= 1'b1;
                                seg_bad <= 1'b1;
                            end else begin
                                dat_valid <= 1'b1;
                                dat_byte  <= hb;
                                acc       <= acc ^ hb;
                                cnt       <= cnt + AW'(1);
                            end
                        end
                        RX_SUM: begin
                            seg_end <= 1'b1;
                            seg_bad <= hk || (hb != acc);
                        end
                        default: ;
                    endcase
                end
            end
        end
    end
endmodule

// File: rtl/evlink_frame_mux.sv
module evlink_frame_mux #(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    ev_code,
    input  logic [7:0]    bus_in,
    input  logic          buf_we,
    input  logic [AW-1:0] buf_waddr,
    input  logic [7:0]    buf_wdata,
    input  logic          send_req,
    input  logic [AW-1:0] send_len,
    output logic [15:0]   tx_word,
    output logic [1:0]    tx_k,
    output logic          tx_busy,
    input  logic [15:0]   rx_word,
    input  logic [1:0]    rx_k,
    output logic          rx_aligned,
    output logic [7:0]    rx_event,
    output logic [7:0]    rx_bus,
    output logic          rx_dat_valid,
    output logic [7:0]    rx_dat_byte,
    output logic          rx_seg_end,
    output logic          rx_seg_bad
);
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;

    evlink_seg_buf #(.DEPTH(DEPTH), .DW(8)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (buf_we & ~tx_busy),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    evlink_tx #(.DEPTH(DEPTH)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_code  (ev_code),
        .bus_in   (bus_in),
        .send_req (send_req),
        .send_len (send_len),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .tx_word  (tx_word),
        .tx_k     (tx_k),
        .busy     (tx_busy)
    );

    evlink_rx #(.DEPTH(DEPTH)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_word   (rx_word),
        .rx_k      (rx_k),
        .aligned   (rx_aligned),
        .ev_out    (rx_event),
        .bus_out   (rx_bus),
        .dat_valid (rx_dat_valid),
        .dat_byte  (rx_dat_byte),
        .seg_end   (rx_seg_end),
        .seg_bad   (rx_seg_bad)
    );
endmodule

// File: rtl/evlink_frame_mux_chk.sv
module evlink_frame_mux_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       send_req,
    input logic [1:0] tx_k,
    input logic       tx_busy,
    input logic       rx_aligned,
    input logic       rx_dat_valid,
    input logic       rx_seg_end,
    input logic       rx_seg_bad
);
    AST_LANE0_NO_K: assert property (@(posedge clk) disable iff (!rst_n)
        tx_k[0] == 1'b0);                                           // R2
    AST_NO_ADJ_K: assert property (@(posedge clk) disable iff (!rst_n)
        tx_k[1] |=> !tx_k[1]);                                      // R3
    AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> $past(send_req));                        // R6
    AST_DAT_NEEDS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dat_valid |-> rx_aligned);                               // R7
    AST_ALIGN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_aligned |=> rx_aligned);                                 // R7
    AST_DAT_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dat_valid |=> !rx_dat_valid);                            // R9
    AST_BAD_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
        rx_seg_bad |-> rx_seg_end);                                 // R10
endmodule

bind evlink_frame_mux evlink_frame_mux_chk u_chk (.*);

// File: tb/test_evlink_frame_mux.sv
module test_evlink_frame_mux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ev_code = '0, bus_in = '0;
    logic        buf_we = 1'b0;
    logic [3:0]  buf_waddr = '0;
    logic [7:0]  buf_wdata = '0;
    logic        send_req = 1'b0;
    logic [3:0]  send_len = '0;
    logic [15:0] tx_word;
    logic [1:0]  tx_k;
    logic        tx_busy;
    logic        inj_en = 1'b0;
    logic [15:0] inj_word = '0;
    logic [1:0]  inj_k = '0;
    logic [15:0] rx_word;
    logic [1:0]  rx_k;
    logic        rx_aligned, rx_dat_valid, rx_seg_end, rx_seg_bad;
    logic [7:0]  rx_event, rx_bus, rx_dat_byte;
    logic        stir = 1'b0;
    logic [7:0]  lfsr = 8'h5A;

    int checks = 0, fails = 0;

    always #2 clk = ~clk;

    assign rx_word = inj_en ? inj_word : tx_word;
    assign rx_k    = inj_en ? inj_k    : tx_k;

    evlink_frame_mux i_evlink_frame_mux (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [8:0]  txq [$];
    logic [7:0]  mbuf [16];
    logic [7:0]  exp_pay [$];
    int          exp_len [$];
    bit          exp_bad [$];
    bit          mph, m_al, m_dph;
    logic [15:0] e_word;
    logic [1:0]  e_k;
    bit          e_busy;
    logic [7:0]  e_ev, e_bus;
    int          seg_bytes = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            txq.delete();
            foreach (mbuf[i]) mbuf[i] = '0;
            mph = 0; m_al = 0; m_dph = 0;
            e_word = '0; e_k = '0; e_busy = 0; e_ev = '0; e_bus = '0;
        end else begin
            bit was_busy;
            logic [8:0] it;
            // receive side, from the word on the link at this edge
            if (!m_al) begin
                if (rx_k[1] && rx_word[15:8] == 8'hBC) begin
                    m_al = 1; m_dph = 0;
                end
            end else begin
                e_ev = rx_k[0] ? 8'h00 : rx_word[7:0];
                if (!m_dph) e_bus = rx_word[15:8];
                m_dph = !m_dph;
            end
            // transmit side
            was_busy = (txq.size() != 0);
            if (!mph) it = {1'b0, bus_in};
            else if (txq.size() != 0) it = txq.pop_front();
            else it = {1'b1, 8'hBC};
            e_word = {it[7:0], ev_code};
            e_k    = {it[8], 1'b0};
            if (buf_we && !was_busy) mbuf[buf_waddr] = buf_wdata;
            if (send_req && !was_busy) begin
                int n;
                logic [7:0] cs;
                n = int'(send_len) + 1;
                cs = '0;
                txq.push_back({1'b1, 8'h5C});
                txq.push_back({1'b0, 8'(n)});
                for (int i = 0; i < n; i++) begin
                    txq.push_back({1'b0, mbuf[i]});
                    cs ^= mbuf[i];
                    if (!inj_en) exp_pay.push_back(mbuf[i]);
                end
                txq.push_back({1'b0, cs});
                if (!inj_en) begin exp_len.push_back(n); exp_bad.push_back(0); end
            end
            e_busy = (txq.size() != 0);
            mph = !mph;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(tx_word[7:0] == e_word[7:0] && tx_k[0] == 1'b0, "R2 low byte", tx_word[7:0], e_word[7:0]);
            chk({tx_k[1], tx_word[15:8]} == {e_k[1], e_word[15:8]}, "R3 R4 R5 high lane",
                {tx_k[1], tx_word[15:8]}, {e_k[1], e_word[15:8]});
            chk(tx_busy == e_busy, "R6 busy", tx_busy, e_busy);
            chk(rx_aligned == m_al, "R7 aligned", rx_aligned, m_al);
            chk(rx_event == e_ev, "R8 event", rx_event, e_ev);
            chk(rx_bus == e_bus, "R8 bus", rx_bus, e_bus);
            if (rx_dat_valid) begin
                seg_bytes++;
                if (exp_pay.size() == 0) chk(0, "R9 unexpected byte", rx_dat_byte, 0);
                else begin
                    logic [7:0] eb;
                    eb = exp_pay.pop_front();
                    chk(rx_dat_byte == eb, "R9 payload", rx_dat_byte, eb);
                end
            end
            if (rx_seg_end) begin
                if (exp_len.size() == 0) chk(0, "R10 unexpected end", 1, 0);
                else begin
                    int el; bit ebd;
                    el = exp_len.pop_front(); ebd = exp_bad.pop_front();
                    chk(seg_bytes == el, "R11 segment length", seg_bytes, el);
                    chk(rx_seg_bad == ebd, "R10 bad flag", rx_seg_bad, ebd);
                end
                seg_bytes = 0;
            end
        end
    end

    // background event/bus stirring
    always @(negedge clk) begin
        if (stir) begin
            lfsr    <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            ev_code <= lfsr;
            bus_in  <= ~{lfsr[3:0], lfsr[7:4]};
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); buf_we = 1; buf_waddr = 4'(a); buf_wdata = 8'(d);
        @(negedge clk); buf_we = 0;
    endtask

    task automatic send(input int l);
        @(negedge clk); send_req = 1; send_len = 4'(l);
        @(negedge clk); send_req = 0;
    endtask

    task automatic drain();
        while (tx_busy) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic put(input logic [7:0] b1, input bit k1);
        @(negedge clk); inj_word = {b1, lfsr}; inj_k = {k1, 1'b0};
    endtask

    task automatic pair(input logic [7:0] b1, input bit k1);
        put(8'h3C, 0);
        put(b1, k1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(tx_word == 0 && tx_k == 0 && tx_busy == 0, "R1 tx reset", tx_word, 0);
        chk(rx_aligned == 0 && rx_event == 0 && rx_bus == 0 && rx_dat_valid == 0
            && rx_seg_end == 0 && rx_seg_bad == 0, "R1 rx reset", rx_aligned, 0);
        ev_code = 8'h11; bus_in = 8'hA7;
        rst_n = 1;
        @(negedge clk);
        chk(tx_word == 16'hA711 && tx_k == 2'b00, "R3 first word is bus", tx_word, 16'hA711);
        @(negedge clk);
        chk(tx_word[15:8] == 8'hBC && tx_k == 2'b10, "R4 idle comma", {tx_k, tx_word}, {2'b10, 16'hBC11});
        @(negedge clk);
        chk(rx_aligned == 1'b1, "R7 lock on first comma", rx_aligned, 1);
        stir = 1;
        for (int i = 0; i < 16; i++) wr(i, i * 17 + 3);
        // 3-byte segment with a second request and a write placed while busy
        send(2);
        @(negedge clk);
        chk(tx_busy == 1'b1, "R6 busy after accept", tx_busy, 1);
        send_req = 1; send_len = 4'd9; buf_we = 1; buf_waddr = 4'd0; buf_wdata = 8'hFF;
        @(negedge clk);
        send_req = 0; buf_we = 0;
        drain();
        chk(exp_len.size() == 0, "R6 ignored request adds no frame", exp_len.size(), 0);
        send(15);   // R11 full length
        drain();
        send(0);    // R11 single byte
        drain();
        chk(exp_pay.size() == 0 && exp_len.size() == 0, "R9 all frames received",
            exp_pay.size() + exp_len.size(), 0);

        // ---------------- receiver fed directly ----------------
        stir = 0;
        @(negedge clk);
        rst_n = 0; inj_en = 1; inj_word = 16'h0000; inj_k = 2'b00;
        @(negedge clk);
        rst_n = 1;
        put(8'hBC, 0); put(8'hBC, 0); put(8'hBC, 0);
        @(negedge clk);
        chk(rx_aligned == 0, "R7 unmarked BC ignored", rx_aligned, 0);
        put(8'hBC, 1);                       // comma: data cycle
        exp_pay.push_back(8'h21); exp_pay.push_back(8'h42);
        exp_len.push_back(2); exp_bad.push_back(1);
        pair(8'h5C, 1); pair(8'h02, 0); pair(8'h21, 0); pair(8'h42, 0);
        pair(8'h00, 0);                      // wrong checksum (0x63 expected)
        exp_len.push_back(0); exp_bad.push_back(1);
        pair(8'h5C, 1); pair(8'd17, 0);      // oversize length
        exp_pay.push_back(8'h07); exp_len.push_back(1); exp_bad.push_back(0);
        pair(8'h5C, 1); pair(8'h01, 0); pair(8'h07, 0); pair(8'h07, 0);
        pair(8'hBC, 1); pair(8'hBC, 1);
        repeat (3) @(negedge clk);
        chk(exp_pay.size() == 0 && exp_len.size() == 0, "R10 injected frames ended",
            exp_pay.size() + exp_len.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #40000;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule